// File: doc/BRIEF.md
# Priority-Level Interrupt Mask Manager

This block keeps a current interrupt priority level and a per-source enable register for a bank of `N_SRC` interrupt sources, and from them drives the effective mask that an interrupt controller applies. The mask is the level-table word selected by the current level, ANDed with the enable register. Source 0 has the highest priority. Level 0 blocks every source. Level `N_SRC` is the least restrictive level and lets every individually enabled source through.

Software or a sequencer issues one command per cycle on a small command port. The commands are: enable a source, disable a source, set the level, and scan. A scan looks at the controller's pending vector, selects the highest-priority eligible source, and reports a vector number for it. It also raises the current level to that source's index and returns the previous level. To restore after servicing, issue a set-level command with the returned value. Every command rewrites the mask register, and its response appears on the cycle after the command is accepted.

The default level table is thermometer coded: entry L has bits 0..L-1 set, so that only sources of higher priority than the one being serviced stay unmasked.

Top module: `prio_mask_mgr`

## Requirements
- R1: After reset, `level_o` equals `N_SRC`, `mask_o` is zero (the enable register is clear), and `rsp_valid_o` is 0.
- R2: A command with `cmd_op_i`=0 (enable) or 1 (disable) and an index below `N_SRC` sets or clears that enable bit. On the next cycle `mask_o` shows the table entry of the current level ANDed with the updated enables, and `rsp_err_o` is 0.
- R3: An enable or disable command whose index is `N_SRC` or more raises `rsp_err_o` on the response cycle and leaves the enable register unchanged.
- R4: A command with `cmd_op_i`=2 (set level) and an argument in 0..`N_SRC` makes `level_o` equal to that argument. The response carries the former level on `rsp_prev_o`, and `mask_o` equals the new table entry ANDed with the enables.
- R5: A set-level command whose argument exceeds `N_SRC` leaves `level_o` unchanged. The mask is still recomputed and rewritten, and `rsp_prev_o` still reports the level.
- R6: At level 0, `mask_o` is zero whatever the enables are. With the default table, entry L has bits 0..L-1 set.
- R7: A command with `cmd_op_i`=3 (scan) selects the lowest-numbered eligible set bit of `pend_i`. On the response cycle `rsp_vec_o` is that index plus `VEC_BASE`, `level_o` is that index, `rsp_prev_o` is the former level, and `rsp_none_o` is 0.
- R8: A scan that finds no eligible bit raises `rsp_none_o` and leaves `level_o` and `mask_o` unchanged.
- R9: Bits cleared in `IGNORE_MASK` and bits below `FIRST_BIT` are never selected by a scan.
- R10: Each accepted command produces `rsp_valid_o`=1 on exactly the following cycle. With no command, `rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 enable, 1 disable, 2 set level, 3 scan |
| cmd_arg_i | input | ARG_W | Source index or level |
| pend_i | input | N_SRC | Pending vector from the controller, sampled on scan |
| level_o | output | LVL_W | Current priority level |
| mask_o | output | N_SRC | Effective mask to the controller |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_err_o | output | 1 | Source index out of range |
| rsp_none_o | output | 1 | Scan found nothing eligible |
| rsp_prev_o | output | LVL_W | Level before the command |
| rsp_vec_o | output | VEC_W | Vector number of the selected source |

## Verification
The assertions assume that `cmd_op_i` and `cmd_arg_i` are known whenever `cmd_valid_i` is high, and that `cmd_valid_i` is low during reset. The bench changes inputs only on falling edges and drops the strobe between commands. The bench instance uses a non-zero `FIRST_BIT` and `VEC_BASE` and an ignore mask with a cleared bit. Random arguments run past both `N_SRC` and the index limit, so the out-of-range and ignored-bit paths are exercised alongside the in-range traffic.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  typedef enum logic [1:0] {
    OP_ENABLE  = 2'd0,
    OP_DISABLE = 2'd1,
    OP_LEVEL   = 2'd2,
    OP_SCAN    = 2'd3
  } pmm_op_e;

  localparam int TBL_MAXW = 1056;

  // thermometer table: entry l has bits 0..l-1 set, entries of width n
  function automatic logic [TBL_MAXW-1:0] thermo_table(int n);
    logic [TBL_MAXW-1:0] t;
    t = '0;
    for (int l = 0; l <= n; l++)
      for (int b = 0; b < l; b++)
        t[l*n + b] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/pmm_pick.sv
module pmm_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0] vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (vec_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pmm_mask.sv
module pmm_mask #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter logic [(N_SRC+1)*N_SRC-1:0] LVL_TABLE = '0
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] entry;

  always_comb begin
    entry = '0;
    for (int l = 0; l <= N_SRC; l++)
      if (lvl_i == LVL_W'(l)) entry = LVL_TABLE[l*N_SRC +: N_SRC];
  end

  assign mask_o = entry & en_i;
endmodule

// File: rtl/prio_mask_mgr.sv
module prio_mask_mgr
  import pmm_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int FIRST_BIT = 0,
  parameter int VEC_BASE = 0,
  parameter int VEC_W = 8,
  parameter logic [N_SRC-1:0] IGNORE_MASK = '1,
  localparam int LVL_W = $clog2(N_SRC+1),
  localparam int ARG_W = LVL_W + 1,
  parameter logic [(N_SRC+1)*N_SRC-1:0] LVL_TABLE =
    ((N_SRC+1)*N_SRC)'(pmm_pkg::thermo_table(N_SRC))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [ARG_W-1:0] cmd_arg_i,
  input  logic [N_SRC-1:0] pend_i,
  output logic [LVL_W-1:0] level_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             rsp_valid_o,
  output logic             rsp_err_o,
  output logic             rsp_none_o,
  output logic [LVL_W-1:0] rsp_prev_o,
  output logic [VEC_W-1:0] rsp_vec_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [N_SRC-1:0] FIRST_MASK = {N_SRC{1'b1}} << FIRST_BIT;

  logic [N_SRC-1:0] en_q, en_d, mask_q, mask_d, elig;
  logic [LVL_W-1:0] lvl_q, lvl_d, pick_idx;
  logic             pick_hit, err_d, none_d;
  logic [VEC_W-1:0] vec_d;
  pmm_op_e          op;

  assign op   = pmm_op_e'(cmd_op_i);
  assign elig = pend_i & IGNORE_MASK & FIRST_MASK;

  pmm_pick #(.N_SRC(N_SRC), .IDX_W(LVL_W)) u_pick (
    .vec_i (elig),
    .hit_o (pick_hit),
    .idx_o (pick_idx)
  );

  always_comb begin
    en_d   = en_q;
    lvl_d  = lvl_q;
    err_d  = 1'b0;
    none_d = 1'b0;
    vec_d  = '0;
    unique case (op)
      OP_ENABLE: begin
        if (cmd_arg_i < ARG_W'(N_SRC)) en_d[cmd_arg_i[IDX_W-1:0]] = 1'b1;
        else err_d = 1'b1;
      end
      OP_DISABLE: begin
        if (cmd_arg_i < ARG_W'(N_SRC)) en_d[cmd_arg_i[IDX_W-1:0]] = 1'b0;
        else err_d = 1'b1;
      end
      OP_LEVEL: begin
        if (cmd_arg_i <= ARG_W'(N_SRC)) lvl_d = cmd_arg_i[LVL_W-1:0];
      end
      OP_SCAN: begin
        if (pick_hit) begin
          lvl_d = pick_idx;
          vec_d = VEC_W'(pick_idx) + VEC_W'(VEC_BASE);
        end else begin
          none_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  pmm_mask #(.N_SRC(N_SRC), .LVL_W(LVL_W), .LVL_TABLE(LVL_TABLE)) u_mask (
    .lvl_i  (lvl_d),
    .en_i   (en_d),
    .mask_o (mask_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= '0;
      lvl_q       <= LVL_W'(N_SRC);
      mask_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_none_o  <= 1'b0;
      rsp_prev_o  <= '0;
      rsp_vec_o   <= '0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        en_q       <= en_d;
        lvl_q      <= lvl_d;
        mask_q     <= mask_d;
        rsp_err_o  <= err_d;
        rsp_none_o <= none_d;
        rsp_prev_o <= lvl_q;
        rsp_vec_o  <= vec_d;
      end
    end
  end

  assign level_o = lvl_q;
  assign mask_o  = mask_q;

  a_r4_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_W'(N_SRC));

  a_r5_bad_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_LEVEL && cmd_arg_i > ARG_W'(N_SRC) |=> lvl_q == $past(lvl_q));

  a_r3_bad_index_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (op == OP_ENABLE || op == OP_DISABLE) && cmd_arg_i >= ARG_W'(N_SRC)
    |=> rsp_err_o && en_q == $past(en_q));

  a_r8_none_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_none_o |-> lvl_q == $past(lvl_q) && mask_q == $past(mask_q));

  a_r7_vec_matches_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_SCAN && pick_hit
    |=> rsp_vec_o == VEC_W'(lvl_q) + VEC_W'(VEC_BASE));

  a_r6_level0_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q == '0 |-> mask_q == '0);

  a_r9_never_masked_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && op == OP_SCAN && pick_hit |-> elig[pick_idx[IDX_W-1:0]]);

  a_r10_rsp_follows_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);
endmodule

// File: tb/prio_mask_mgr_test.sv
`timescale 1ns/1ps
module prio_mask_mgr_test;
  localparam int N = 8;
  localparam int LW = 4;
  localparam int AW = 5;
  localparam int VW = 8;
  localparam int FB = 1;
  localparam int VB = 16;
  localparam logic [N-1:0] IGN = 8'h7F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_arg = '0;
  logic [N-1:0] pend = '0;
  logic [LW-1:0] level, rsp_prev;
  logic [N-1:0] mask;
  logic rsp_valid, rsp_err, rsp_none;
  logic [VW-1:0] rsp_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_en = '0;
  int m_lvl = N;

  always #2.5 clk = ~clk;

  prio_mask_mgr #(.N_SRC(N), .FIRST_BIT(FB), .VEC_BASE(VB), .VEC_W(VW),
                  .IGNORE_MASK(IGN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_arg_i(cmd_arg), .pend_i(pend), .level_o(level), .mask_o(mask),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_none_o(rsp_none),
    .rsp_prev_o(rsp_prev), .rsp_vec_o(rsp_vec));

  function automatic logic [N-1:0] thermo(int l);
    logic [N-1:0] t = '0;
    for (int b = 0; b < l; b++) t[b] = 1'b1;
    return t;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(int op, int arg, logic [N-1:0] p);
    int prev, idx;
    logic e_err, e_none;
    logic [N-1:0] elig;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_arg = arg[AW-1:0]; pend = p;
    prev = m_lvl; e_err = 1'b0; e_none = 1'b0; idx = -1;
    case (op)
      0: if (arg < N) m_en[arg] = 1'b1; else e_err = 1'b1;
      1: if (arg < N) m_en[arg] = 1'b0; else e_err = 1'b1;
      2: if (arg <= N) m_lvl = arg;
      default: begin
        elig = p & IGN & ~thermo(FB);
        for (int i = N-1; i >= 0; i--) if (elig[i]) idx = i;
        if (idx < 0) e_none = 1'b1; else m_lvl = idx;
      end
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 rsp_valid", int'(rsp_valid), 1);
    check((op < 2) ? "R2/R3 err" : "R3 err", int'(rsp_err), int'(e_err));
    check((op == 3) ? "R8 none" : "R8 none idle", int'(rsp_none), int'(e_none));
    check((op == 2) ? (arg > N ? "R5 level" : "R4 level") : "R7 level", int'(level), m_lvl);
    check((m_lvl == 0) ? "R6 mask" : "R2 mask", int'(mask), int'(thermo(m_lvl) & m_en));
    check("R4 prev", int'(rsp_prev), prev);
    if (op == 3 && idx >= 0) check("R7 vec", int'(rsp_vec), idx + VB);
    if (op == 3) check("R9 pick", int'(idx >= 0 && (idx < FB || !IGN[idx])), 0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 level", int'(level), N);
    check("R1 mask", int'(mask), 0);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", int'(rsp_valid), 0);
    // directed corners
    run_cmd(0, 0, '0); run_cmd(0, 3, '0); run_cmd(0, 5, '0); run_cmd(0, 7, '0);
    run_cmd(0, 9, '0);                 // R3 bad enable index
    run_cmd(1, 12, '0);                // R3 bad disable index
    run_cmd(0, 8, '0);                 // R3 index at limit
    run_cmd(1, 3, '0);                 // R2 disable
    run_cmd(2, 0, '0);                 // R6 level 0
    run_cmd(2, 20, '0);                // R5 out of range
    run_cmd(2, 9, '0);                 // R5 just over N
    run_cmd(2, N, '0);                 // R4 back to N
    run_cmd(3, 0, 8'h00);              // R8 nothing pending
    run_cmd(3, 0, 8'h81);              // R9 only ignored/low bits
    run_cmd(3, 0, 8'h2B);              // R7 picks bit 1
    run_cmd(2, N, '0);                 // R4 restore
    run_cmd(3, 0, 8'hA0);              // R7 picks bit 5
    // random mix
    for (int k = 0; k < 400; k++) begin
      int op, arg;
      op  = $urandom_range(0, 3);
      arg = $urandom_range(0, 12);
      run_cmd(op, arg, N'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule